// File: doc/BRIEF.md
# Bufferless Router Local Access Stage

This block is the local-access pipeline stage of a bufferless deflection router. It sits in front of the permutation network. Each cycle it sees one flit slot per input link. It takes out at most one flit that is addressed to this node and sends it to the reassembly storage. It then places a waiting flit from the local injection FIFO into an empty slot, if one is free after the ejection.

The golden packet is named by a source node and a request ID. When several local flits compete for the eject port, a flit of the golden packet has first claim, so the golden packet always makes progress at its destination. New traffic has the lowest priority. It only fills a slot that is empty, and it never pushes in-flight traffic out of the network. Local flits that lose the eject port keep their slots and go on into the network, where they are deflected. All outputs of the stage are registered.

Top module: `ie_stage`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output slot valid and the eject valid are 0.
- R2: A flit word is `{data, req, src, dst}`. `dst` sits in bits [NODE_W-1:0], `src` in [2*NODE_W-1:NODE_W], `req` in the next REQ_W bits, and `data` in the top DATA_W bits. A valid flit whose `dst` is not the local node leaves in the same slot index, unchanged, one clock after it is presented.
- R3: At most one flit is ejected per cycle. The ejected flit appears on the eject output one clock later. Its slot is left empty unless an injection fills it.
- R4: A valid local flit whose `src` and `req` equal the golden identity wins ejection over non-golden local flits. Among several golden local flits, the lowest-numbered port wins.
- R5: When no golden local flit is present, the lowest-numbered valid local flit is ejected.
- R6: A local flit that is not ejected stays in its own slot, unchanged, one clock later.
- R7: When the FIFO head is valid, the lowest-numbered slot that is empty after ejection takes the head flit one clock later. A slot freed by ejection in the same cycle counts as empty. Other empty slots stay invalid.
- R8: The pop output is asserted in the same cycle if and only if the head is valid and an empty slot exists after ejection.
- R9: With no valid FIFO head, nothing is injected, empty slots remain invalid and pop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_node_i | input | NODE_W | ID of this node |
| gold_src_i | input | NODE_W | Source node of the golden packet |
| gold_req_i | input | REQ_W | Request ID of the golden packet |
| in_vld_i | input | P | Valid bit of each incoming slot |
| in_flit_i | input | P*FW | Incoming flit words; slot i at [i*FW +: FW] |
| inj_vld_i | input | 1 | Injection FIFO head is valid |
| inj_flit_i | input | FW | Injection FIFO head flit |
| inj_pop_o | output | 1 | Head is taken this cycle |
| out_vld_o | output | P | Registered slot valid bits toward the permutation network |
| out_flit_o | output | P*FW | Registered slot flit words |
| ej_vld_o | output | 1 | Registered eject valid |
| ej_flit_o | output | FW | Registered ejected flit |

## Verification
Pop is a combinational reply to the current inputs. The bench samples it 1 ns after it drives the stimulus on the falling edge. Slot outputs and the eject output pass through one register. They are compared at the next falling edge, half a period after the capturing rising edge, against a bench model of the inputs from one cycle earlier. Random traffic with biased destinations and golden identities is mixed with directed cases: ports that all want to eject, full slots with a pending head, an injection into a freed slot, and an idle FIFO.

// File: rtl/ie_pkg.sv
package ie_pkg;

   localparam int MAX_PORTS = 32;

   // how an output slot is filled in the next cycle
   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_PASS  = 2'd1,
      SLOT_INJ   = 2'd2
   } slot_src_e;

   // isolate the least significant set bit
   function automatic logic [MAX_PORTS-1:0] lowest_onehot(input logic [MAX_PORTS-1:0] x);
      return x & (~x + {{(MAX_PORTS-1){1'b0}}, 1'b1});
   endfunction

endpackage

// File: rtl/ie_slot_match.sv
module ie_slot_match #(
   parameter int P      = 4,
   parameter int NODE_W = 6,
   parameter int REQ_W  = 3,
   parameter int FW     = 34
) (
   input  logic [P-1:0]    vld_i,
   input  logic [P*FW-1:0] flit_i,
   input  logic [NODE_W-1:0] my_node_i,
   input  logic [NODE_W-1:0] gold_src_i,
   input  logic [REQ_W-1:0]  gold_req_i,
   output logic [P-1:0]    local_o,
   output logic [P-1:0]    gold_o
);
   localparam int SRC_LO = NODE_W;
   localparam int REQ_LO = 2*NODE_W;

   for (genvar i = 0; i < P; i++) begin : g_slot
      logic [FW-1:0] f;
      assign f          = flit_i[i*FW +: FW];
      assign local_o[i] = vld_i[i] && (f[NODE_W-1:0] == my_node_i);
      assign gold_o[i]  = local_o[i] && (f[SRC_LO +: NODE_W] == gold_src_i)
                                     && (f[REQ_LO +: REQ_W] == gold_req_i);
   end
endmodule

// File: rtl/ie_eject_arb.sv
module ie_eject_arb
   import ie_pkg::*;
#(
   parameter int P = 4
) (
   input  logic [P-1:0] local_i,
   input  logic [P-1:0] gold_i,
   output logic [P-1:0] gnt_o
);
   logic [MAX_PORTS-1:0] pool, pick;

   always_comb begin
      pool = '0;
      if (|gold_i) pool[P-1:0] = gold_i;
      else         pool[P-1:0] = local_i;
      pick  = lowest_onehot(pool);
      gnt_o = pick[P-1:0];
   end

   always_comb begin
      a_r3_one_eject: assert ($onehot0(gnt_o));
   end
endmodule

// File: rtl/ie_inject_sel.sv
module ie_inject_sel
   import ie_pkg::*;
#(
   parameter int P = 4
) (
   input  logic [P-1:0] occ_i,
   input  logic         head_vld_i,
   output logic [P-1:0] gnt_o,
   output logic         pop_o
);
   logic [MAX_PORTS-1:0] free_slots, pick;

   always_comb begin
      free_slots = '0;
      free_slots[P-1:0] = ~occ_i;
      pick  = lowest_onehot(free_slots);
      gnt_o = head_vld_i ? pick[P-1:0] : '0;
      pop_o = |gnt_o;
   end
endmodule

// File: rtl/ie_stage.sv
module ie_stage
   import ie_pkg::*;
#(
   parameter int P      = 4,
   parameter int NODE_W = 6,
   parameter int REQ_W  = 3,
   parameter int DATA_W = 16,
   localparam int FW    = DATA_W + REQ_W + 2*NODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] my_node_i,
   input  logic [NODE_W-1:0] gold_src_i,
   input  logic [REQ_W-1:0]  gold_req_i,
   input  logic [P-1:0]      in_vld_i,
   input  logic [P*FW-1:0]   in_flit_i,
   input  logic              inj_vld_i,
   input  logic [FW-1:0]     inj_flit_i,
   output logic              inj_pop_o,
   output logic [P-1:0]      out_vld_o,
   output logic [P*FW-1:0]   out_flit_o,
   output logic              ej_vld_o,
   output logic [FW-1:0]     ej_flit_o
);
   localparam int SRC_LO = NODE_W;
   localparam int REQ_LO = 2*NODE_W;

   if (P < 1 || P > MAX_PORTS) begin : g_bad_ports
      $error("ie_stage: P must lie in 1..MAX_PORTS");
   end
   if (NODE_W < 1 || REQ_W < 1 || DATA_W < 0) begin : g_bad_fields
      $error("ie_stage: field widths out of range");
   end

   logic [P-1:0] is_local, is_gold, ej_gnt, occ_after, inj_gnt;
   logic [P-1:0] vld_d;
   logic [P*FW-1:0] flit_d;
   logic [FW-1:0] ej_flit_d;
   logic ej_any;

   ie_slot_match #(.P(P), .NODE_W(NODE_W), .REQ_W(REQ_W), .FW(FW)) u_match (
      .vld_i      (in_vld_i),
      .flit_i     (in_flit_i),
      .my_node_i  (my_node_i),
      .gold_src_i (gold_src_i),
      .gold_req_i (gold_req_i),
      .local_o    (is_local),
      .gold_o     (is_gold)
   );

   ie_eject_arb #(.P(P)) u_eject (
      .local_i (is_local),
      .gold_i  (is_gold),
      .gnt_o   (ej_gnt)
   );

   assign ej_any    = |ej_gnt;
   assign occ_after = in_vld_i & ~ej_gnt;

   ie_inject_sel #(.P(P)) u_inject (
      .occ_i      (occ_after),
      .head_vld_i (inj_vld_i),
      .gnt_o      (inj_gnt),
      .pop_o      (inj_pop_o)
   );

   always_comb begin
      ej_flit_d = '0;
      for (int i = 0; i < P; i++) begin
         if (ej_gnt[i]) ej_flit_d = ej_flit_d | in_flit_i[i*FW +: FW];
      end
   end

   for (genvar i = 0; i < P; i++) begin : g_next
      slot_src_e how;
      always_comb begin
         if (inj_gnt[i])        how = SLOT_INJ;
         else if (occ_after[i]) how = SLOT_PASS;
         else                   how = SLOT_EMPTY;
         case (how)
            SLOT_INJ: begin
               vld_d[i]            = 1'b1;
               flit_d[i*FW +: FW]  = inj_flit_i;
            end
            SLOT_PASS: begin
               vld_d[i]            = 1'b1;
               flit_d[i*FW +: FW]  = in_flit_i[i*FW +: FW];
            end
            default: begin
               vld_d[i]            = 1'b0;
               flit_d[i*FW +: FW]  = in_flit_i[i*FW +: FW];
            end
         endcase
      end

      a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld_i[i] && !is_local[i]) |=>
            (out_vld_o[i] && out_flit_o[i*FW +: FW] == $past(in_flit_i[i*FW +: FW])));

      a_r6_loser_stays: assert property (@(posedge clk) disable iff (!rst_n)
         (is_local[i] && !ej_gnt[i]) |=>
            (out_vld_o[i] && out_flit_o[i*FW +: FW] == $past(in_flit_i[i*FW +: FW])));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld_o  <= '0;
         out_flit_o <= '0;
         ej_vld_o   <= 1'b0;
         ej_flit_o  <= '0;
      end else begin
         out_vld_o  <= vld_d;
         out_flit_o <= flit_d;
         ej_vld_o   <= ej_any;
         ej_flit_o  <= ej_flit_d;
      end
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (out_vld_o == '0 && !ej_vld_o));

   a_r3_eject_is_local: assert property (@(posedge clk) disable iff (!rst_n)
      ej_vld_o |-> (ej_flit_o[NODE_W-1:0] == $past(my_node_i)));

   a_r3_local_ejects: assert property (@(posedge clk) disable iff (!rst_n)
      (|is_local) |=> ej_vld_o);

   a_r4_golden_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|is_gold) |=> (ej_vld_o && ej_flit_o[SRC_LO +: NODE_W] == $past(gold_src_i)
                               && ej_flit_o[REQ_LO +: REQ_W] == $past(gold_req_i)));

   a_r7_slot_count: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(out_vld_o) ==
                $countones($past(in_vld_i)) - int'($past(ej_any)) + int'($past(inj_pop_o))));

   a_r8_pop_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pop_o |-> inj_vld_i);

   a_r8_no_pop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      ((&in_vld_i) && !(|is_local)) |-> !inj_pop_o);

endmodule

// File: tb/ie_stage_tb.sv
module ie_stage_tb;
   localparam int P  = 4;
   localparam int NW = 6;
   localparam int RW = 3;
   localparam int DW = 16;
   localparam int FW = DW + RW + 2*NW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NW-1:0] my_node = '0, gold_src = '0;
   logic [RW-1:0] gold_req = '0;
   logic [P-1:0]  in_vld = '0;
   logic [FW-1:0] in_f [P];
   logic [P*FW-1:0] in_flit;
   logic inj_vld = 1'b0;
   logic [FW-1:0] inj_flit = '0;
   logic inj_pop;
   logic [P-1:0] out_vld;
   logic [P*FW-1:0] out_flit;
   logic ej_vld;
   logic [FW-1:0] ej_flit;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < P; i++) in_flit[i*FW +: FW] = in_f[i];
   end

   ie_stage #(.P(P), .NODE_W(NW), .REQ_W(RW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .my_node_i(my_node), .gold_src_i(gold_src),
      .gold_req_i(gold_req), .in_vld_i(in_vld), .in_flit_i(in_flit),
      .inj_vld_i(inj_vld), .inj_flit_i(inj_flit), .inj_pop_o(inj_pop),
      .out_vld_o(out_vld), .out_flit_o(out_flit), .ej_vld_o(ej_vld), .ej_flit_o(ej_flit)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic          e_vld [P];
   logic [FW-1:0] e_flit [P];
   string         e_tag [P];
   logic          e_ej, e_pop;
   logic [FW-1:0] e_ejf;
   string         e_ejtag;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] mk(input logic [NW-1:0] d, input logic [NW-1:0] s,
                                         input logic [RW-1:0] r, input logic [DW-1:0] x);
      return {x, r, s, d};
   endfunction

   // expected behaviour from the requirements
   task automatic model();
      int ej = -1, inj = -1, firstgold = -1, firstloc = -1;
      logic [P-1:0] occ;
      for (int i = 0; i < P; i++) begin
         bit loc = in_vld[i] && in_f[i][NW-1:0] == my_node;
         bit gld = loc && in_f[i][NW +: NW] == gold_src && in_f[i][2*NW +: RW] == gold_req;
         if (gld && firstgold < 0) firstgold = i;
         if (loc && firstloc < 0)  firstloc = i;
      end
      ej = (firstgold >= 0) ? firstgold : firstloc;
      e_ej    = (ej >= 0);
      e_ejf   = (ej >= 0) ? in_f[ej] : '0;
      e_ejtag = (firstgold >= 0) ? "R4" : ((ej >= 0) ? "R5" : "R3");
      occ = in_vld;
      if (ej >= 0) occ[ej] = 1'b0;
      if (inj_vld) begin
         for (int i = P-1; i >= 0; i--) if (!occ[i]) inj = i;
      end
      e_pop = (inj >= 0);
      for (int i = 0; i < P; i++) begin
         if (i == inj) begin
            e_vld[i] = 1'b1; e_flit[i] = inj_flit; e_tag[i] = "R7";
         end else if (occ[i]) begin
            e_vld[i] = 1'b1; e_flit[i] = in_f[i];
            e_tag[i] = (in_f[i][NW-1:0] == my_node) ? "R6" : "R2";
         end else begin
            e_vld[i] = 1'b0; e_flit[i] = '0;
            e_tag[i] = (i == ej) ? "R3" : (inj_vld ? "R7" : "R9");
         end
      end
   endtask

   // inputs are already set on a falling edge; check pop, then registered outputs
   task automatic step();
      #1;
      model();
      chk(inj_pop == e_pop, inj_vld ? "R8" : "R9", "pop", 64'(inj_pop), 64'(e_pop));
      @(negedge clk);
      for (int i = 0; i < P; i++) begin
         chk(out_vld[i] == e_vld[i], e_tag[i], $sformatf("slot%0d valid", i),
             64'(out_vld[i]), 64'(e_vld[i]));
         if (e_vld[i])
            chk(out_flit[i*FW +: FW] == e_flit[i], e_tag[i], $sformatf("slot%0d flit", i),
                64'(out_flit[i*FW +: FW]), 64'(e_flit[i]));
      end
      chk(ej_vld == e_ej, e_ejtag, "eject valid", 64'(ej_vld), 64'(e_ej));
      if (e_ej) chk(ej_flit == e_ejf, e_ejtag, "eject flit", 64'(ej_flit), 64'(e_ejf));
   endtask

   function automatic logic [FW-1:0] rnd_flit();
      logic [NW-1:0] d = ($urandom % 2 == 0) ? my_node : NW'($urandom);
      logic [NW-1:0] s = ($urandom % 3 == 0) ? gold_src : NW'($urandom);
      logic [RW-1:0] r = ($urandom % 3 == 0) ? gold_req : RW'($urandom);
      return mk(d, s, r, DW'($urandom));
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < P; i++) in_f[i] = '0;
      my_node = 6'd9; gold_src = 6'd3; gold_req = 3'd5;
      in_vld = '1; inj_vld = 1'b1;
      for (int i = 0; i < P; i++) in_f[i] = mk(6'd9, 6'd1, 3'd0, 16'h1);
      repeat (3) @(negedge clk);
      chk(out_vld == '0, "R1", "slots in reset", 64'(out_vld), 64'd0);
      chk(!ej_vld, "R1", "eject in reset", 64'(ej_vld), 64'd0);
      in_vld = '0; inj_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_vld == '0, "R1", "slots after reset", 64'(out_vld), 64'd0);
      chk(!ej_vld, "R1", "eject after reset", 64'(ej_vld), 64'd0);

      // all local, port 2 golden: R4, freed slot takes head: R7
      in_vld = '1; inj_vld = 1'b1; inj_flit = mk(6'd20, 6'd9, 3'd1, 16'hAAAA);
      in_f[0] = mk(6'd9, 6'd1, 3'd2, 16'h0100);
      in_f[1] = mk(6'd9, 6'd3, 3'd4, 16'h0101);
      in_f[2] = mk(6'd9, 6'd3, 3'd5, 16'h0102);
      in_f[3] = mk(6'd9, 6'd3, 3'd5, 16'h0103);
      step();
      // full of transit traffic with a waiting head: R8
      for (int i = 0; i < P; i++) in_f[i] = mk(6'(i + 1), 6'd2, 3'd0, 16'(16'h0200 + i));
      step();
      // R5 lowest local, R7 lowest empty is the freed slot 1
      in_vld = 4'b1011;
      in_f[0] = mk(6'd4, 6'd2, 3'd1, 16'h0300);
      in_f[1] = mk(6'd9, 6'd7, 3'd1, 16'h0301);
      in_f[3] = mk(6'd9, 6'd6, 3'd2, 16'h0303);
      step();
      // golden at port 3 beats local at port 0
      in_vld = 4'b1001;
      in_f[0] = mk(6'd9, 6'd7, 3'd1, 16'h0400);
      in_f[3] = mk(6'd9, 6'd3, 3'd5, 16'h0403);
      inj_vld = 1'b0;
      step();
      // idle FIFO, mostly empty: R9
      in_vld = 4'b0100; in_f[2] = mk(6'd1, 6'd1, 3'd1, 16'h0500);
      step();

      for (int n = 0; n < 3000; n++) begin
         if (n % 500 == 0) begin
            my_node = NW'($urandom); gold_src = NW'($urandom); gold_req = RW'($urandom);
         end
         in_vld = P'($urandom);
         for (int i = 0; i < P; i++) in_f[i] = rnd_flit();
         inj_vld = ($urandom % 4 != 0);
         inj_flit = mk(NW'($urandom), my_node, RW'($urandom), DW'($urandom));
         step();
      end
      finish_run();
   end
endmodule